// File: doc/BRIEF.md
# Lockable Input Crossbar Select Bank

This block holds a bank of routing selectors for an input crossbar. Every crossbar output has its own select register. The value in that register picks which of the implemented input lines is copied to the output. Software programs the selectors through a small word-addressed register port. A write reaches a register only while a global protection-enable input is held high.

Each selector has a lock bit in a shared lock register. Setting a lock bit freezes its selector. Once set, the bit stays set until system reset, so a routing configuration can be sealed against later stray writes. Reads are never restricted. The routed outputs are combinational from the current selector values and the input lines.

Top module: `xbar_sel_bank`

## Requirements
- R1: After reset every selector reads 0 and the lock register reads 0, so every output carries input line 0.
- R2: With protection enabled, a write to word offset k-1 (k = 1..NUM_OUT) stores data bits [SEL_W-1:0] in selector k. In the cycle after the write edge, output k carries input line n, where n is the stored value. Reading the offset returns the value zero-extended to 32 bits.
- R3: While protEn is low, writes to any offset, the lock register included, change nothing.
- R4: The lock register is at offset 0x1E, and bit k-1 locks selector k. Writing a 1 sets that bit, and writing a 0 leaves it as it was. One write may set several bits. Bits 31:16 read as 0 and ignore writes.
- R5: A write to a locked selector is discarded and the selector keeps its value. Reads of a locked selector still return its current value.
- R6: Only reset clears a lock bit. After reset the selectors accept writes again.
- R7: A selector value of NUM_IN or more drives its output to 0.
- R8: Offsets other than 0x0..NUM_OUT-1 and 0x1E read as 0, and writes to them change no register.
- R9: An output follows a change on its selected input line in the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| protEn | input | 1 | Protection enable; high lets writes through |
| wrEn | input | 1 | Write strobe for one cycle |
| addr | input | ADDR_W | Word offset for reads and writes |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data for addr, combinational |
| inSig | input | NUM_IN | Input lines to be routed |
| outSig | output | NUM_OUT | Routed crossbar outputs; bit k-1 is output k |

## Verification
The bench builds the block with NUM_IN = 20 and keeps the default 16 outputs and 16-bit selectors. With 20 inputs, selector values just below and above the limit are both reachable, so the highest valid line (19), the first out-of-range value (20) and the all-ones value can each be written and observed. A 5-bit address reaches the lock offset 0x1E, unlisted offsets between the selectors and the lock register, and offset 0x1F above it.

// File: rtl/xbar_sel_pkg.sv
package xbar_sel_pkg;
  localparam int IDX_W = 8;

  typedef struct packed {
    logic             selWr;
    logic             lockWr;
    logic [IDX_W-1:0] idx;
  } xbarStrobe_t;
endpackage

// File: rtl/xbar_sel_ctrl.sv
module xbar_sel_ctrl
  import xbar_sel_pkg::*;
#(
  parameter int NUM_OUT  = 16,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 5,
  parameter int LOCK_OFS = 30
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               protEn,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NUM_OUT-1:0] lockData,
  output xbarStrobe_t        strobe,
  output logic [NUM_OUT-1:0] lockQ
);
  logic isSel;
  logic isLock;
  logic hitLocked;
  logic wrOk;

  assign wrOk   = wrEn && protEn;
  assign isLock = (addr == ADDR_W'(LOCK_OFS));

  always_comb begin
    isSel     = 1'b0;
    hitLocked = 1'b0;
    for (int k = 0; k < NUM_OUT; k++) begin
      if (addr == ADDR_W'(k)) begin
        isSel     = 1'b1;
        hitLocked = lockQ[k];
      end
    end
  end

  always_comb begin
    strobe        = '0;
    strobe.idx    = IDX_W'(addr);
    strobe.selWr  = wrOk && isSel && !hitLocked;
    strobe.lockWr = wrOk && isLock;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockQ <= '0;
    end else if (strobe.lockWr) begin
      lockQ <= lockQ | lockData;
    end
  end

  // R4
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lockQ & $past(lockQ)) == $past(lockQ));

  // R3
  no_unprot_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    !protEn |=> lockQ == $past(lockQ));

  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.selWr, strobe.lockWr}));
endmodule

// File: rtl/xbar_sel_dp.sv
module xbar_sel_dp
  import xbar_sel_pkg::*;
#(
  parameter int NUM_IN   = 32,
  parameter int NUM_OUT  = 16,
  parameter int SEL_W    = 16,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 5,
  parameter int LOCK_OFS = 30
) (
  input  logic               clk,
  input  logic               rstN,
  input  xbarStrobe_t        strobe,
  input  logic [SEL_W-1:0]   selData,
  input  logic [NUM_OUT-1:0] lockQ,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NUM_IN-1:0]  inSig,
  output logic [NUM_OUT-1:0] outSig,
  output logic [DATA_W-1:0]  rdData
);
  logic [SEL_W-1:0] selQ [NUM_OUT];

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        selQ[k] <= '0;
      end else if (strobe.selWr && (strobe.idx == IDX_W'(k))) begin
        selQ[k] <= selData;
      end
    end

    always_comb begin
      outSig[k] = 1'b0;
      for (int j = 0; j < NUM_IN; j++) begin
        if (selQ[k] == SEL_W'(j)) outSig[k] = inSig[j];
      end
    end

    // R5
    locked_sel_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
      lockQ[k] |=> $stable(selQ[k]));
  end

  always_comb begin
    rdData = '0;
    for (int k = 0; k < NUM_OUT; k++) begin
      if (addr == ADDR_W'(k)) rdData = DATA_W'(selQ[k]);
    end
    if (addr == ADDR_W'(LOCK_OFS)) rdData = DATA_W'(lockQ);
  end
endmodule

// File: rtl/xbar_sel_bank.sv
module xbar_sel_bank
  import xbar_sel_pkg::*;
#(
  parameter int NUM_IN   = 32,
  parameter int NUM_OUT  = 16,
  parameter int SEL_W    = 16,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 5,
  parameter int LOCK_OFS = 30
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               protEn,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  input  logic [NUM_IN-1:0]  inSig,
  output logic [NUM_OUT-1:0] outSig
);
  xbarStrobe_t        strobe;
  logic [NUM_OUT-1:0] lockQ;

  xbar_sel_ctrl #(
    .NUM_OUT(NUM_OUT), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LOCK_OFS(LOCK_OFS)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .protEn(protEn), .wrEn(wrEn), .addr(addr),
    .lockData(wrData[NUM_OUT-1:0]), .strobe(strobe), .lockQ(lockQ)
  );

  xbar_sel_dp #(
    .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .SEL_W(SEL_W), .DATA_W(DATA_W),
    .ADDR_W(ADDR_W), .LOCK_OFS(LOCK_OFS)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .selData(wrData[SEL_W-1:0]),
    .lockQ(lockQ), .addr(addr), .inSig(inSig), .outSig(outSig), .rdData(rdData)
  );
endmodule

// File: tb/xbar_sel_bank_tb.sv
module xbar_sel_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 20;
  localparam int NO = 16;
  localparam int LOCK_ADDR = 30;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        protEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [NI-1:0] inSig = '0;
  logic [NO-1:0] outSig;

  int testCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  logic [15:0] expSel [NO];
  logic [15:0] expLock;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbar_sel_bank #(.NUM_IN(NI)) dut_i (
    .clk(clk), .rstN(rstN), .protEn(protEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .inSig(inSig), .outSig(outSig)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic expOut(input int k);
    return (expSel[k] < NI) ? inSig[expSel[k]] : 1'b0;
  endfunction

  // Drive at the falling edge; the write lands at the next rising edge.
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  task automatic checkAllOut(input string req);
    for (int k = 0; k < NO; k++) begin
      check(outSig[k] == expOut(k), req, 32'(outSig[k]), 32'(expOut(k)));
    end
  endtask

  task automatic checkAllRegs(input string req);
    logic [31:0] d;
    for (int k = 0; k < NO; k++) begin
      rd(5'(k), d);
      check(d == 32'(expSel[k]), req, d, 32'(expSel[k]));
    end
    rd(5'(LOCK_ADDR), d);
    check(d == 32'(expLock), req, d, 32'(expLock));
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    for (int k = 0; k < NO; k++) expSel[k] = '0;
    expLock = '0;
  endtask

  task automatic t_reset();
    inSig = 20'hA5C3E;
    #1;
    checkAllRegs("R1 reset registers");
    checkAllOut("R1 reset routing to line 0");
    inSig = 20'hA5C3F;
    #1;
    checkAllOut("R1 reset routing to line 0 high");
  endtask

  task automatic t_route();
    logic [31:0] d;
    protEn = 1'b1;
    wr(5'd2, 32'hABCD_0007); expSel[2] = 16'd7;
    wr(5'd15, 32'd19);       expSel[15] = 16'd19;
    wr(5'd0, 32'd1);         expSel[0] = 16'd1;
    rd(5'd2, d);
    check(d == 32'd7, "R2 readback zero-extended", d, 32'd7);
    for (int p = 0; p < 4; p++) begin
      inSig = 20'(32'h3_5A5A + p * 32'h1_1111);
      #1;
      checkAllOut("R2 routing pattern");
    end
    inSig = '0;
    #1;
    inSig[19] = 1'b1;
    #1;
    check(outSig[15] == 1'b1, "R9 same-cycle follow rise", 32'(outSig[15]), 32'd1);
    inSig[19] = 1'b0;
    #1;
    check(outSig[15] == 1'b0, "R9 same-cycle follow fall", 32'(outSig[15]), 32'd0);
  endtask

  task automatic t_prot();
    protEn = 1'b0;
    wr(5'd3, 32'd5);
    wr(5'(LOCK_ADDR), 32'h0000_FFFF);
    checkAllRegs("R3 writes ignored without protEn");
    protEn = 1'b1;
  endtask

  task automatic t_range();
    inSig = '1;
    wr(5'd4, 32'd20); expSel[4] = 16'd20;
    #1;
    check(outSig[4] == 1'b0, "R7 value NUM_IN gives 0", 32'(outSig[4]), 32'd0);
    wr(5'd5, 32'hFFFF); expSel[5] = 16'hFFFF;
    #1;
    check(outSig[5] == 1'b0, "R7 all-ones gives 0", 32'(outSig[5]), 32'd0);
    wr(5'd6, 32'd19); expSel[6] = 16'd19;
    #1;
    check(outSig[6] == 1'b1, "R7 value NUM_IN-1 routes", 32'(outSig[6]), 32'd1);
    checkAllRegs("R7 range readback");
  endtask

  task automatic t_unlisted();
    logic [31:0] d;
    wr(5'h10, 32'h0000_0003);
    wr(5'h1F, 32'hFFFF_FFFF);
    wr(5'h1D, 32'h0000_FFFF);
    rd(5'h10, d);
    check(d == 32'd0, "R8 unlisted 0x10 reads 0", d, 32'd0);
    rd(5'h1F, d);
    check(d == 32'd0, "R8 unlisted 0x1F reads 0", d, 32'd0);
    checkAllRegs("R8 unlisted writes change nothing");
  endtask

  task automatic t_lock();
    logic [31:0] d;
    wr(5'(LOCK_ADDR), 32'h0000_0005); expLock = 16'h0005;
    rd(5'(LOCK_ADDR), d);
    check(d == 32'h5, "R4 set multiple lock bits", d, 32'h5);
    wr(5'd0, 32'd9);
    wr(5'd2, 32'd11);
    wr(5'd1, 32'd12); expSel[1] = 16'd12;
    checkAllRegs("R5 locked writes discarded, reads allowed");
    inSig = 20'h0_0A82;
    #1;
    checkAllOut("R5 locked routing unchanged");
    wr(5'(LOCK_ADDR), 32'hFFFF_0002); expLock = 16'h0007;
    rd(5'(LOCK_ADDR), d);
    check(d == 32'h7, "R4 reserved bits ignored", d, 32'h7);
    wr(5'(LOCK_ADDR), 32'h0);
    rd(5'(LOCK_ADDR), d);
    check(d == 32'h7, "R4 writing 0 keeps lock", d, 32'h7);
    wr(5'(LOCK_ADDR), 32'h0000_FFFF); expLock = 16'hFFFF;
    wr(5'd10, 32'd3);
    checkAllRegs("R6 full lock holds");
  endtask

  task automatic t_reset2();
    logic [31:0] d;
    doReset();
    checkAllRegs("R6 reset clears locks");
    wr(5'd0, 32'd9); expSel[0] = 16'd9;
    rd(5'd0, d);
    check(d == 32'd9, "R6 writable after reset", d, 32'd9);
  endtask

  initial begin
    for (int k = 0; k < NO; k++) expSel[k] = '0;
    expLock = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_route();
    t_prot();
    t_range();
    t_unlisted();
    t_lock();
    t_reset2();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      testCnt++;
      failCnt++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end
endmodule